// File: doc/BRIEF.md
# Sensor Monitor Word Register File

This block holds the register set of a small hardware-monitor slave. A host reaches it through a one-request-per-cycle register port: an index, a read/write flag and a 16-bit write word go in, and a 16-bit read word comes back one clock later. Thirty-two locations are decoded. Six of them in the middle of the map are 16 bits wide. All others are one byte wide, and a word read returns that byte in both halves.

Several locations do not return what was stored in them. They return live sensor codes that arrive on input pins: one temperature code, two fan counts and four voltage codes. The pins carry codes that are already converted. A few indices mask their write data. One index redirects its write into another location. A control bit restores every location to its power-up value in a single cycle. The block also exports the two fan-divisor selects from its divisor register, so that the external counter can apply them.

Top module: `hwm_regfile`

## Requirements
- R1: Only the low five bits of `req_idx` select a location. Indices that differ only in bits 7:5 reach the same register.
- R2: After reset, location 0x00 and location 0x01 each hold 0x80, 0x05 holds 0xC7, 0x06 holds 0xC2, 0x08 holds 0x6464, 0x09 to 0x0C each hold 0xDAC5, and 0x0F holds 0xF8. Every other location holds 0. Both divisor selects reset to 3.
- R3: Locations 0x07 to 0x0C return a full 16-bit word. Every other location returns its byte in bits 7:0 and the same byte in bits 15:8.
- R4: A read of 0x04 returns `temp_code`. A read of 0x07 returns `fan1_code` in bits 15:8 and `fan2_code` in bits 7:0. Both values are sampled at the read request, and writes to these locations do not change what is read.
- R5: A read of 0x14 returns `volt_a_code`, a read of 0x13 returns `volt_b_code`, a read of 0x0D returns `volt_c_code` and a read of 0x15 returns `vdd_code`.
- R6: A write to 0x03 stores the low byte ANDed with 0xFC. If bit 7 of the write word is 1, every location instead returns to its R2 value, so 0x03 then reads 0. A read in the very next cycle sees the R2 values, and the divisor selects return to 3.
- R7: A write to 0x0F stores the low byte ANDed with 0xF8. From the next cycle on, `fan1_div` equals bits 7:6 of the stored value and `fan2_div` equals bits 5:4. The selects change at no other time, except through R6.
- R8: A write to 0x11 stores the low byte ANDed with 0x7F.
- R9: A write to index 0x0A leaves location 0x0A unchanged. Its low byte goes into the storage of location 0x13, which still reads the live code given in R5.
- R10: A write to any other byte-wide location stores bits 7:0 and drops bits 15:8. A write to 0x08 to 0x0C stores all 16 bits.
- R11: `rsp_valid` is 1 exactly one cycle after each read request. `rsp_data` then reflects every write accepted before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 8 | Register index (bits 4:0 decoded) |
| req_wdata | input | 16 | Write word |
| temp_code | input | 8 | Live temperature code |
| fan1_code | input | 8 | Live fan-1 count |
| fan2_code | input | 8 | Live fan-2 count |
| volt_a_code | input | 8 | Live voltage code, channel A |
| volt_b_code | input | 8 | Live voltage code, channel B |
| volt_c_code | input | 8 | Live voltage code, channel C |
| vdd_code | input | 8 | Live supply voltage code |
| rsp_valid | output | 1 | Read word valid |
| rsp_data | output | 16 | Read word |
| fan1_div | output | 2 | Fan-1 divisor select (power of two) |
| fan2_div | output | 2 | Fan-2 divisor select (power of two) |

## Verification
A stored byte that is corrupted, or a write mask that is wrong, stays hidden until the host reads that location. It then shows one cycle after the read request. For this reason the bench reads every location many times, both between random writes and right after a reinitialise. Faults in the divisor register appear sooner: the select outputs differ in the cycle after the write, with no read needed. Faults in live-code routing show on any read of the affected index, provided the sensor inputs have changed since the previous read.

// File: rtl/hwm_regfile_pkg.sv
package hwm_regfile_pkg;

    localparam int unsigned CODE_W = 8;
    localparam int unsigned WORD_W = 2 * CODE_W;
    localparam int unsigned IX_W   = 5;
    localparam int unsigned NREG   = 1 << IX_W;

    typedef logic [IX_W-1:0]   ix_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [WORD_W-1:0] word_t;

    // indices whose behaviour is fixed by the register map
    localparam ix_t IX_CTRL      = 5'h03;
    localparam ix_t IX_TEMP      = 5'h04;
    localparam ix_t IX_FANS      = 5'h07;
    localparam ix_t IX_REDIR     = 5'h0A;
    localparam ix_t IX_WIDE_LAST = 5'h0C;
    localparam ix_t IX_VOLT_C    = 5'h0D;
    localparam ix_t IX_FANDIV    = 5'h0F;
    localparam ix_t IX_AUX       = 5'h11;
    localparam ix_t IX_VOLT_B    = 5'h13;
    localparam ix_t IX_VOLT_A    = 5'h14;
    localparam ix_t IX_VDD       = 5'h15;

    localparam code_t MASK_CTRL   = 8'hFC;
    localparam code_t MASK_FANDIV = 8'hF8;
    localparam code_t MASK_AUX    = 8'h7F;
    localparam int unsigned INIT_BIT = 7;

    function automatic logic is_wide(ix_t ix);
        return (ix >= IX_FANS) && (ix <= IX_WIDE_LAST);
    endfunction

    function automatic word_t default_of(ix_t ix);
        word_t v;
        case (ix)
            5'h00, 5'h01:                 v = 16'h0080;
            5'h05:                        v = 16'h00C7;
            5'h06:                        v = 16'h00C2;
            5'h08:                        v = 16'h6464;
            5'h09, 5'h0A, 5'h0B, 5'h0C:   v = 16'hDAC5;
            IX_FANDIV:                    v = 16'h00F8;
            default:                      v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/hwm_wr_decode.sv
module hwm_wr_decode
    import hwm_regfile_pkg::*;
(
    input  logic  wr_en,
    input  ix_t   wr_ix,
    input  word_t wr_word,
    output logic  st_en,
    output ix_t   st_ix,
    output word_t st_word,
    output logic  init_req
);

    code_t lo_b;
    assign lo_b = wr_word[CODE_W-1:0];

    always_comb begin
        st_en    = wr_en;
        st_ix    = wr_ix;
        init_req = 1'b0;
        st_word  = {{CODE_W{1'b0}}, lo_b};
        if (wr_ix == IX_CTRL) begin
            st_word  = {{CODE_W{1'b0}}, lo_b & MASK_CTRL};
            init_req = wr_en & wr_word[INIT_BIT];
        end else if (wr_ix == IX_FANDIV) begin
            st_word = {{CODE_W{1'b0}}, lo_b & MASK_FANDIV};
        end else if (wr_ix == IX_AUX) begin
            st_word = {{CODE_W{1'b0}}, lo_b & MASK_AUX};
        end else if (wr_ix == IX_REDIR) begin
            st_ix = IX_VOLT_B;
        end else if (is_wide(wr_ix)) begin
            st_word = wr_word;
        end
    end

endmodule

// File: rtl/hwm_rd_format.sv
module hwm_rd_format
    import hwm_regfile_pkg::*;
(
    input  ix_t   rd_ix,
    input  word_t stored,
    input  code_t temp_code,
    input  code_t fan1_code,
    input  code_t fan2_code,
    input  code_t volt_a_code,
    input  code_t volt_b_code,
    input  code_t volt_c_code,
    input  code_t vdd_code,
    output word_t rd_word
);

    word_t raw;

    always_comb begin
        case (rd_ix)
            IX_TEMP:   raw = {{CODE_W{1'b0}}, temp_code};
            IX_FANS:   raw = {fan1_code, fan2_code};
            IX_VOLT_C: raw = {{CODE_W{1'b0}}, volt_c_code};
            IX_VOLT_B: raw = {{CODE_W{1'b0}}, volt_b_code};
            IX_VOLT_A: raw = {{CODE_W{1'b0}}, volt_a_code};
            IX_VDD:    raw = {{CODE_W{1'b0}}, vdd_code};
            default:   raw = stored;
        endcase
        if (is_wide(rd_ix))
            rd_word = raw;
        else
            rd_word = {raw[CODE_W-1:0], raw[CODE_W-1:0]};
    end

endmodule

// File: rtl/hwm_regfile.sv
module hwm_regfile
    import hwm_regfile_pkg::*;
#(
    parameter int unsigned REQ_IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REQ_IDX_W-1:0]  req_idx,
    input  logic [WORD_W-1:0]     req_wdata,
    input  logic [CODE_W-1:0]     temp_code,
    input  logic [CODE_W-1:0]     fan1_code,
    input  logic [CODE_W-1:0]     fan2_code,
    input  logic [CODE_W-1:0]     volt_a_code,
    input  logic [CODE_W-1:0]     volt_b_code,
    input  logic [CODE_W-1:0]     volt_c_code,
    input  logic [CODE_W-1:0]     vdd_code,
    output logic                  rsp_valid,
    output logic [WORD_W-1:0]     rsp_data,
    output logic [1:0]            fan1_div,
    output logic [1:0]            fan2_div
);

    localparam int unsigned HI_W = REQ_IDX_W - IX_W;

    typedef struct packed {
        logic [NREG-1:0][WORD_W-1:0] regs;
        logic                        rsp_valid;
        word_t                       rsp_data;
    } state_t;

    state_t s_d, s_q;

    ix_t   ix;
    logic  unused_idx_hi;
    logic  st_en, init_req;
    ix_t   st_ix;
    word_t st_word, rd_word;
    logic [NREG-1:0][WORD_W-1:0] dflt;

    assign ix            = req_idx[IX_W-1:0];
    assign unused_idx_hi = ^req_idx[REQ_IDX_W-1 -: HI_W];

    for (genvar g = 0; g < NREG; g++) begin : g_dflt
        assign dflt[g] = default_of(ix_t'(g));
    end

    hwm_wr_decode u_wr (
        .wr_en    (req_valid & req_write),
        .wr_ix    (ix),
        .wr_word  (req_wdata),
        .st_en    (st_en),
        .st_ix    (st_ix),
        .st_word  (st_word),
        .init_req (init_req)
    );

    hwm_rd_format u_rd (
        .rd_ix       (ix),
        .stored      (s_q.regs[ix]),
        .temp_code   (temp_code),
        .fan1_code   (fan1_code),
        .fan2_code   (fan2_code),
        .volt_a_code (volt_a_code),
        .volt_b_code (volt_b_code),
        .volt_c_code (volt_c_code),
        .vdd_code    (vdd_code),
        .rd_word     (rd_word)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        if (req_valid && !req_write) begin
            s_d.rsp_valid = 1'b1;
            s_d.rsp_data  = rd_word;
        end
        if (init_req)
            s_d.regs = dflt;
        else if (st_en)
            s_d.regs[st_ix] = st_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.regs      <= dflt;
            s_q.rsp_valid <= 1'b0;
            s_q.rsp_data  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_data  = s_q.rsp_data;
    assign fan1_div  = s_q.regs[IX_FANDIV][7:6];
    assign fan2_div  = s_q.regs[IX_FANDIV][5:4];

endmodule

// File: rtl/hwm_regfile_chk.sv
module hwm_regfile_chk
    import hwm_regfile_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_idx,
    input logic [15:0] req_wdata,
    input logic [7:0]  temp_code,
    input logic        rsp_valid,
    input logic [15:0] rsp_data,
    input logic [1:0]  fan1_div,
    input logic [1:0]  fan2_div
);

    ix_t  cix;
    logic rd_req, wr_req;
    assign cix    = req_idx[IX_W-1:0];
    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);  // R11
    AST_RSP_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_req));  // R11
    AST_NARROW_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !is_wide(cix)) |=> (rsp_data[15:8] == rsp_data[7:0]));  // R3
    AST_TEMP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cix == IX_TEMP) |=> (rsp_data[7:0] == $past(temp_code)));  // R4
    AST_INIT_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && cix == IX_CTRL && req_wdata[7]) |=> (fan1_div == 2'b11 && fan2_div == 2'b11));  // R6
    AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && cix == IX_FANDIV) |=> (fan1_div == $past(req_wdata[7:6]) && fan2_div == $past(req_wdata[5:4])));  // R7
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && (cix == IX_FANDIV || cix == IX_CTRL)) |=> ($stable(fan1_div) && $stable(fan2_div)));  // R7

endmodule

bind hwm_regfile hwm_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_idx   (req_idx),
    .req_wdata (req_wdata),
    .temp_code (temp_code),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .fan1_div  (fan1_div),
    .fan2_div  (fan2_div)
);

// File: tb/sim_hwm_regfile.sv
module sim_hwm_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_idx = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  temp_code = 8'h95, fan1_code = 8'h2D, fan2_code = 8'h2E;
    logic [7:0]  volt_a_code = 8'h60, volt_b_code = 8'hB0, volt_c_code = 8'hBB, vdd_code = 8'hC8;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [1:0]  fan1_div, fan2_div;

    always #4 clk = ~clk;

    hwm_regfile u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata), .temp_code(temp_code),
        .fan1_code(fan1_code), .fan2_code(fan2_code), .volt_a_code(volt_a_code),
        .volt_b_code(volt_b_code), .volt_c_code(volt_c_code), .vdd_code(vdd_code),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fan1_div(fan1_div), .fan2_div(fan2_div)
    );

    int        nchk = 0, nfail = 0;
    string     cur_tag = "R2";
    string     exp_tag = "R2";
    bit        armed = 0;
    bit        exp_valid = 0;
    logic [15:0] exp_data = '0;
    logic [1:0]  exp_f1 = 2'd3, exp_f2 = 2'd3;
    logic [15:0] mreg [32];

    // ---------------- behavioural reference ----------------
    task automatic model_init();
        for (int i = 0; i < 32; i++) mreg[i] = 16'h0000;
        mreg[0] = 16'h80; mreg[1] = 16'h80; mreg[5] = 16'hC7; mreg[6] = 16'hC2;
        mreg[8] = 16'h6464;
        for (int i = 9; i <= 12; i++) mreg[i] = 16'hDAC5;
        mreg[15] = 16'hF8;
    endtask

    function automatic logic [15:0] model_read(int i);
        logic [15:0] v;
        if (i == 4) v = {8'h00, temp_code};
        else if (i == 7) v = {fan1_code, fan2_code};
        else if (i == 13) v = {8'h00, volt_c_code};
        else if (i == 19) v = {8'h00, volt_b_code};
        else if (i == 20) v = {8'h00, volt_a_code};
        else if (i == 21) v = {8'h00, vdd_code};
        else v = mreg[i];
        if (i < 7 || i > 12) v = {v[7:0], v[7:0]};
        return v;
    endfunction

    task automatic model_write(int i, logic [15:0] d);
        if (i == 3) begin
            if (d[7]) model_init();
            else mreg[3] = {8'h00, d[7:0] & 8'hFC};
        end else if (i == 15) mreg[15] = {8'h00, d[7:0] & 8'hF8};
        else if (i == 17) mreg[17] = {8'h00, d[7:0] & 8'h7F};
        else if (i == 10) mreg[19] = {8'h00, d[7:0]};
        else if (i >= 7 && i <= 12) mreg[i] = d;
        else mreg[i] = {8'h00, d[7:0]};
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_init();
            exp_valid = 0;
            exp_tag   = "R2";
        end else begin
            exp_tag = cur_tag;
            if (req_valid && !req_write) begin
                exp_valid = 1;
                exp_data  = model_read(int'(req_idx[4:0]));
            end else begin
                exp_valid = 0;
            end
            if (req_valid && req_write) model_write(int'(req_idx[4:0]), req_wdata);
        end
        exp_f1 = mreg[15][7:6];
        exp_f2 = mreg[15][5:4];
        armed  = 1;
    end

    // ---------------- comparison every clock ----------------
    always @(negedge clk) begin
        if (armed) begin
            nchk++;
            if (rsp_valid !== exp_valid) begin
                nfail++;
                $display("FAIL %s/R11 rsp_valid actual %0b expected %0b", exp_tag, rsp_valid, exp_valid);
            end
            if (exp_valid) begin
                nchk++;
                if (rsp_data !== exp_data) begin
                    nfail++;
                    $display("FAIL %s rsp_data actual %h expected %h", exp_tag, rsp_data, exp_data);
                end
            end
            nchk++;
            if (fan1_div !== exp_f1 || fan2_div !== exp_f2) begin
                nfail++;
                $display("FAIL %s/R7 divisors actual %0d,%0d expected %0d,%0d",
                         exp_tag, fan1_div, fan2_div, exp_f1, exp_f2);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic op_wr(input logic [7:0] ix, input logic [15:0] d, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_idx = ix; req_wdata = d; cur_tag = tag;
    endtask

    task automatic op_rd(input logic [7:0] ix, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_idx = ix; req_wdata = 16'hFFFF; cur_tag = tag;
    endtask

    task automatic op_idle(input string tag);
        @(negedge clk);
        req_valid = 0; req_write = 0; cur_tag = tag;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1357_9BDF;
        repeat (3) @(posedge clk);
        op_idle("R2");
        rst_n = 1;
        op_idle("R2");
        // R2 / R3 / R4 / R5: full sweep of reset image
        for (int i = 0; i < 32; i++) op_rd(8'(i), "R2");
        // R1: aliasing through upper index bits
        op_rd(8'h25, "R1");
        op_wr(8'hE2, 16'hABCD, "R1");
        op_rd(8'h02, "R1");
        op_rd(8'h62, "R1");
        // R10: narrow stores low byte only; wide keeps all bits
        op_wr(8'h1C, 16'h5A3C, "R10");
        op_rd(8'h1C, "R10");
        op_wr(8'h09, 16'h1234, "R10");
        op_rd(8'h09, "R3");
        op_wr(8'h0C, 16'hFEDC, "R10");
        op_rd(8'h0C, "R3");
        // R4 / R5: live codes, writes to live indices not visible
        op_wr(8'h04, 16'h0011, "R4");
        op_wr(8'h07, 16'h2222, "R4");
        @(negedge clk);
        temp_code = 8'h3A; fan1_code = 8'h81; fan2_code = 8'h07;
        volt_a_code = 8'h11; volt_b_code = 8'h22; volt_c_code = 8'h33; vdd_code = 8'h44;
        req_valid = 0; cur_tag = "R4";
        op_rd(8'h04, "R4");
        op_rd(8'h07, "R4");
        op_rd(8'h0D, "R5");
        op_rd(8'h13, "R5");
        op_rd(8'h14, "R5");
        op_rd(8'h15, "R5");
        // R7: divisor register
        op_wr(8'h0F, 16'hFF5F, "R7");
        op_rd(8'h0F, "R7");
        op_wr(8'h0F, 16'h0097, "R7");
        op_idle("R7");
        // R8
        op_wr(8'h11, 16'h12FF, "R8");
        op_rd(8'h11, "R8");
        // R9: redirected write
        op_wr(8'h0A, 16'h3377, "R9");
        op_rd(8'h0A, "R9");
        op_rd(8'h13, "R9");
        // R6: mask then reinitialise, read in next cycle
        op_wr(8'h03, 16'h007F, "R6");
        op_rd(8'h03, "R6");
        op_wr(8'h03, 16'h0080, "R6");
        op_rd(8'h03, "R6");
        op_rd(8'h0F, "R6");
        op_rd(8'h02, "R6");
        op_rd(8'h09, "R6");
        op_rd(8'h11, "R6");
        // R11: back-to-back reads after writes
        op_wr(8'h10, 16'h00A5, "R11");
        op_rd(8'h10, "R11");
        op_rd(8'h10, "R11");
        op_idle("R11");
        // mixed pseudo-random traffic
        for (int n = 0; n < 600; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            if (seed[31:29] == 3'd0) begin
                @(negedge clk);
                temp_code = seed[7:0]; fan1_code = seed[15:8]; fan2_code = seed[23:16];
                volt_a_code = seed[11:4]; volt_b_code = seed[19:12]; vdd_code = seed[27:20];
                volt_c_code = ~seed[7:0]; req_valid = 0; cur_tag = "R5";
            end else if (seed[28]) begin
                op_wr({seed[2:0], seed[20:16]}, seed[15:0] & (seed[21] ? 16'hFF7F : 16'hFFFF), "R10");
            end else begin
                op_rd({seed[9:7], seed[20:16]}, "R3");
            end
        end
        op_idle("R11");
        op_idle("R11");
        summary();
        $finish;
    end

endmodule